// File: doc/BRIEF.md
# Product-Term Logic Cell

This block is one small programmable logic cell. A bank of configuration words sets it up: the words describe a set of product terms over an 18-bit input bus, how each output gathers those terms, and how each output is timed. After setup the cell computes four data outputs and one output-enable signal from the input bus. Each output is either a fast OR of four private terms or a wide OR of any of the twenty data terms followed by a programmable inversion. Each output can also be taken straight from that logic or from a flip-flop.

Three further product terms act as controls. One clears the output flip-flops asynchronously. One drives the output-enable signal. One can replace the global clock as the flip-flop clock. The cell accepts configuration writes only while the active-low global reset is held. The outputs are meant to be routed back as inputs of neighbouring cells, so the cell adds no buffering of its own.

Top module: `ptl_cell`

## Requirements
- R1: A product term is a word of 36 bits. Bit 2i enables the true literal of input i and bit 2i+1 enables its complement. A term with no literal enabled evaluates to 1.
- R2: A term is the AND of its enabled literals. A term that enables both the true and the complement literal of the same input is always 0.
- R3: The words are numbered as follows. Words 0 to 19 are the data terms, word 20 is the reset term, word 21 is the enable term and word 22 is the clock term. When the full-path bit of an output is 0, output k is the OR of data terms 4k to 4k+3, with no inversion.
- R4: Word 23+k configures output k. Bits 19:0 select the data terms, bit 20 picks the full path, bit 21 makes the output registered and bit 22 inverts. On the full path, output k is the OR of the selected data terms XOR the invert bit.
- R5: An output whose registered bit is 0 follows the input bus in the same cycle.
- R6: With the clock-select bit (word 27 bit 0) at 0, a registered output takes its logic value at each rising edge of `clk`.
- R7: With the clock-select bit at 1, registered outputs update on rising edges of the clock term and ignore `clk`.
- R8: The reset term clears all output registers at once, without waiting for a clock edge. The registers stay cleared while the term is 1.
- R9: A low `rst_n` clears all output registers at once, without waiting for a clock edge.
- R10: `oe` equals the enable term at all times.
- R11: A configuration write (`cfg_wr` high at a rising edge of `clk`) takes effect only while `rst_n` is low. With `rst_n` high it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock; also clocks configuration writes |
| rst_n | input | 1 | Active-low global reset; configuration window while low |
| in_bus | input | 18 | Shared logic inputs |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word number (0 to 27) |
| cfg_data | input | 36 | Configuration word value |
| dout | output | 4 | Data outputs |
| oe | output | 1 | Output-enable from the enable term |

## Verification
The assertions check on every cycle that contradictory terms stay low, that a registered output on the global clock carries the logic value of the previous edge, that an active reset term leaves the registers cleared, and that the stored configuration stays frozen after reset is released. The bench's scenarios are the only evidence for the rest. They compare random configurations and inputs against a reference model of the term, OR and XOR paths. They also cover clocking from a product term, where the global clock has no effect, and a reset term that clears between clock edges. Finally they show a write attempted out of reset that leaves the outputs as they were, followed by the same write accepted under reset.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
    localparam int unsigned IN_W     = 18;
    localparam int unsigned OUT_N    = 4;
    localparam int unsigned DATA_PT  = 20;
    localparam int unsigned BYP_PT   = 4;
    localparam int unsigned CTRL_PT  = 3;
    localparam int unsigned PT_N     = DATA_PT + CTRL_PT;
    localparam int unsigned PT_RST   = DATA_PT;
    localparam int unsigned PT_OE    = DATA_PT + 1;
    localparam int unsigned PT_CLK   = DATA_PT + 2;
    localparam int unsigned LIT_W    = 2 * IN_W;
    localparam int unsigned OC_FULL  = DATA_PT;
    localparam int unsigned OC_REG   = DATA_PT + 1;
    localparam int unsigned OC_INV   = DATA_PT + 2;
    localparam int unsigned OC_W     = DATA_PT + 3;
    localparam int unsigned OC_BASE  = PT_N;
    localparam int unsigned GC_ADDR  = PT_N + OUT_N;
    localparam int unsigned WORD_N   = GC_ADDR + 1;
    localparam int unsigned ADDR_W   = $clog2(WORD_N);

    typedef logic [LIT_W-1:0] lits_t;
    typedef logic [OC_W-1:0]  ocw_t;

    // true when some input has both literals enabled
    function automatic logic lits_contra(input lits_t w);
        logic c;
        c = 1'b0;
        for (int i = 0; i < int'(IN_W); i++) begin
            c = c | (w[2*i] & w[2*i+1]);
        end
        return c;
    endfunction
endpackage

// File: rtl/ptl_cfg_store.sv
module ptl_cfg_store
    import ptl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [LIT_W-1:0]              cfg_data,
    output lits_t [PT_N-1:0]              pt_lits_o,
    output logic  [OUT_N-1:0][DATA_PT-1:0] oc_mask_o,
    output logic  [OUT_N-1:0]             oc_full_o,
    output logic  [OUT_N-1:0]             oc_reg_o,
    output logic  [OUT_N-1:0]             oc_inv_o,
    output logic                          clk_sel_o
);
    typedef struct packed {
        lits_t [PT_N-1:0] pt;
        ocw_t  [OUT_N-1:0] oc;
        logic              clk_sel;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr && !rst_n) begin
            for (int p = 0; p < int'(PT_N); p++) begin
                if (cfg_addr == ADDR_W'(p)) st_d.pt[p] = cfg_data;
            end
            for (int k = 0; k < int'(OUT_N); k++) begin
                if (cfg_addr == ADDR_W'(OC_BASE + k)) st_d.oc[k] = cfg_data[OC_W-1:0];
            end
            if (cfg_addr == ADDR_W'(GC_ADDR)) st_d.clk_sel = cfg_data[0];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pt_lits_o = st_q.pt;
    assign clk_sel_o = st_q.clk_sel;

    for (genvar k = 0; k < int'(OUT_N); k++) begin : g_oc
        assign oc_mask_o[k] = st_q.oc[k][DATA_PT-1:0];
        assign oc_full_o[k] = st_q.oc[k][OC_FULL];
        assign oc_reg_o[k]  = st_q.oc[k][OC_REG];
        assign oc_inv_o[k]  = st_q.oc[k][OC_INV];
    end

    // R11: writes out of reset leave the configuration untouched
    a_r11_frozen_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> $stable(st_q));
endmodule

// File: rtl/ptl_and_array.sv
module ptl_and_array
    import ptl_pkg::*;
(
    input  logic [IN_W-1:0]  in_bus,
    input  lits_t [PT_N-1:0] pt_lits_i,
    output logic [PT_N-1:0]  term_o
);
    for (genvar p = 0; p < int'(PT_N); p++) begin : g_term
        logic [IN_W-1:0] lit_ok;
        always_comb begin
            for (int i = 0; i < int'(IN_W); i++) begin
                lit_ok[i] = (~pt_lits_i[p][2*i]   |  in_bus[i]) &
                            (~pt_lits_i[p][2*i+1] | ~in_bus[i]);
            end
        end
        assign term_o[p] = &lit_ok;
    end
endmodule

// File: rtl/ptl_or_xor.sv
module ptl_or_xor
    import ptl_pkg::*;
(
    input  logic [DATA_PT-1:0]             dterm_i,
    input  logic [OUT_N-1:0][DATA_PT-1:0]  oc_mask_i,
    input  logic [OUT_N-1:0]               oc_full_i,
    input  logic [OUT_N-1:0]               oc_inv_i,
    output logic [OUT_N-1:0]               logic_o
);
    for (genvar k = 0; k < int'(OUT_N); k++) begin : g_out
        logic byp_or, full_or;
        assign byp_or  = |dterm_i[k*BYP_PT +: BYP_PT];
        assign full_or = (|(dterm_i & oc_mask_i[k])) ^ oc_inv_i[k];
        assign logic_o[k] = oc_full_i[k] ? full_or : byp_or;
    end
endmodule

// File: rtl/ptl_out_reg.sv
module ptl_out_reg
    import ptl_pkg::*;
(
    input  logic             reg_clk,
    input  logic             reg_rst,
    input  logic [OUT_N-1:0] d_i,
    output logic [OUT_N-1:0] q_o
);
    typedef struct packed {
        logic [OUT_N-1:0] q;
    } oreg_t;

    oreg_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.q = d_i;
    end

    always_ff @(posedge reg_clk or posedge reg_rst) begin
        if (reg_rst) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o = st_q.q;
endmodule

// File: rtl/ptl_cell.sv
module ptl_cell
    import ptl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   in_bus,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LIT_W-1:0]  cfg_data,
    output logic [OUT_N-1:0]  dout,
    output logic              oe
);
    lits_t [PT_N-1:0]              pt_lits;
    logic  [OUT_N-1:0][DATA_PT-1:0] oc_mask;
    logic  [OUT_N-1:0]             oc_full, oc_reg, oc_inv;
    logic                          clk_sel;
    logic  [PT_N-1:0]              terms;
    logic  [OUT_N-1:0]             logic_w, q_w;
    logic                          reg_clk, reg_rst;

    ptl_cfg_store u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .pt_lits_o (pt_lits),
        .oc_mask_o (oc_mask),
        .oc_full_o (oc_full),
        .oc_reg_o  (oc_reg),
        .oc_inv_o  (oc_inv),
        .clk_sel_o (clk_sel)
    );

    ptl_and_array u_and (
        .in_bus    (in_bus),
        .pt_lits_i (pt_lits),
        .term_o    (terms)
    );

    ptl_or_xor u_orx (
        .dterm_i   (terms[DATA_PT-1:0]),
        .oc_mask_i (oc_mask),
        .oc_full_i (oc_full),
        .oc_inv_i  (oc_inv),
        .logic_o   (logic_w)
    );

    assign reg_clk = clk_sel ? terms[PT_CLK] : clk;
    assign reg_rst = ~rst_n | terms[PT_RST];

    ptl_out_reg u_reg (
        .reg_clk (reg_clk),
        .reg_rst (reg_rst),
        .d_i     (logic_w),
        .q_o     (q_w)
    );

    for (genvar k = 0; k < int'(OUT_N); k++) begin : g_dout
        assign dout[k] = oc_reg[k] ? q_w[k] : logic_w[k];

        // R6: registered output on the global clock carries last edge's logic value
        a_r6_capture_on_clk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clk_sel && oc_reg[k] && !terms[PT_RST]) |=>
                (terms[PT_RST] || dout[k] == $past(logic_w[k])));
    end

    assign oe = terms[PT_OE];

    for (genvar p = 0; p < int'(PT_N); p++) begin : g_chk
        // R2: a term with both literals of one input never evaluates high
        a_r2_contra_low: assert property (@(posedge clk) disable iff (!rst_n)
            lits_contra(pt_lits[p]) |-> !terms[p]);
    end

    // R8: while the reset term is high the output registers hold zero
    a_r8_term_clears: assert property (@(posedge clk) disable iff (!rst_n)
        terms[PT_RST] |-> (q_w == '0));
endmodule

// File: tb/ptl_cell_tb.sv
`timescale 1ns/1ps
module ptl_cell_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] in_bus = '0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [35:0] cfg_data = '0;
    logic [3:0]  dout;
    logic        oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [35:0] bw [28];

    always #4 clk = ~clk;

    ptl_cell dut_i (
        .clk(clk), .rst_n(rst_n), .in_bus(in_bus), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .dout(dout), .oe(oe)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic term_val(input logic [35:0] w, input logic [17:0] v);
        logic r = 1'b1;
        for (int i = 0; i < 18; i++) begin
            if (w[2*i] && !v[i]) r = 1'b0;
            if (w[2*i+1] && v[i]) r = 1'b0;
        end
        return r;
    endfunction

    function automatic logic out_val(input int k, input logic [17:0] v);
        logic byp = 1'b0;
        logic full = 1'b0;
        for (int p = 0; p < 4; p++) byp |= term_val(bw[4*k+p], v);
        for (int p = 0; p < 20; p++) if (bw[23+k][p]) full |= term_val(bw[p], v);
        full ^= bw[23+k][22];
        return bw[23+k][20] ? full : byp;
    endfunction

    // contradictory literal pair on input 0: always 0
    function automatic logic [35:0] contra_w();
        return 36'h3;
    endfunction

    function automatic logic [35:0] rand_term(input bit no17);
        logic [35:0] w = '0;
        for (int i = 0; i < 18; i++) begin
            int r = int'($urandom % 12);
            if (r == 0) w[2*i] = 1'b1;
            if (r == 1) w[2*i+1] = 1'b1;
        end
        if (no17) w[35:34] = 2'b00;
        return w;
    endfunction

    task automatic program_all();
        @(negedge clk);
        rst_n = 1'b0;
        for (int a = 0; a < 28; a++) begin
            @(negedge clk);
            cfg_wr = 1'b1; cfg_addr = 5'(a); cfg_data = bw[a];
        end
        @(negedge clk);
        cfg_wr = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic rand_cfg(input bit no17);
        for (int p = 0; p < 20; p++) bw[p] = rand_term(no17);
        bw[20] = contra_w();
        bw[21] = rand_term(1'b0);
        bw[22] = contra_w();
        for (int k = 0; k < 4; k++) begin
            bw[23+k] = '0;
            bw[23+k][19:0] = 20'($urandom);
            bw[23+k][22:20] = 3'($urandom);
        end
        bw[27] = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));

        // ---- random configurations on the global clock (R2 R3 R4 R5 R6 R10)
        for (int c = 0; c < 6; c++) begin
            rand_cfg(1'b0);
            program_all();
            for (int k = 0; k < 4; k++)
                if (bw[23+k][21]) check(dout[k] == 1'b0, "R9 reset state", 8'(dout[k]), 8'h0);
            for (int n = 0; n < 150; n++) begin
                logic [17:0] v;
                @(negedge clk);
                v = 18'($urandom);
                in_bus = v;
                #1;
                check(oe == term_val(bw[21], v), "R10 oe", 8'(oe), 8'(term_val(bw[21], v)));
                for (int k = 0; k < 4; k++)
                    if (!bw[23+k][21])
                        check(dout[k] == out_val(k, v), bw[23+k][20] ? "R4 R5 full comb" : "R3 R5 bypass comb",
                              8'(dout[k]), 8'(out_val(k, v)));
                @(posedge clk);
                #1;
                for (int k = 0; k < 4; k++)
                    if (bw[23+k][21])
                        check(dout[k] == out_val(k, v), "R6 registered", 8'(dout[k]), 8'(out_val(k, v)));
            end
        end

        // ---- directed configuration (R1 R2 R3 R8 R9 R11)
        for (int p = 0; p < 23; p++) bw[p] = contra_w();
        bw[0] = '0;                 // empty term
        bw[4] = 36'h1 << 10;        // true literal of input 5
        bw[8] = '0;                 // empty term for out2
        bw[20] = 36'h1 << 32;       // reset term: input 16 true
        bw[23] = '0;                // out0 bypass comb
        bw[24] = '0;                // out1 bypass comb
        bw[25] = 36'h1 << 21;       // out2 bypass registered
        bw[26] = '0;
        bw[27] = '0;
        program_all();
        for (int n = 0; n < 8; n++) begin
            logic [17:0] v;
            @(negedge clk);
            v = 18'($urandom) & ~18'h10000;
            in_bus = v;
            #1;
            check(dout[0] == 1'b1, "R1 empty term", 8'(dout[0]), 8'h1);
            check(dout[1] == v[5], "R2 single literal", 8'(dout[1]), 8'(v[5]));
        end
        @(posedge clk); #1;
        check(dout[2] == 1'b1, "R6 capture", 8'(dout[2]), 8'h1);
        @(negedge clk); in_bus[16] = 1'b1; #1;
        check(dout[2] == 1'b0, "R8 async term reset", 8'(dout[2]), 8'h0);
        @(posedge clk); #1;
        check(dout[2] == 1'b0, "R8 held in reset", 8'(dout[2]), 8'h0);
        @(negedge clk); in_bus[16] = 1'b0;
        @(posedge clk); #1;
        check(dout[2] == 1'b1, "R8 release", 8'(dout[2]), 8'h1);
        // write attempt out of reset: out0 full path, empty mask -> would be 0
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 5'd23; cfg_data = 36'h1 << 20;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 5'd0; cfg_data = contra_w();
        @(negedge clk); cfg_wr = 1'b0;
        @(posedge clk); #1;
        check(dout[0] == 1'b1, "R11 write ignored", 8'(dout[0]), 8'h1);
        // global reset clears register at once
        @(negedge clk); rst_n = 1'b0; #1;
        check(dout[2] == 1'b0, "R9 async global reset", 8'(dout[2]), 8'h0);
        // same write under reset is accepted
        cfg_wr = 1'b1; cfg_addr = 5'd23; cfg_data = 36'h1 << 20;
        @(negedge clk); cfg_wr = 1'b0; #1;
        check(dout[0] == 1'b0, "R11 write accepted in reset", 8'(dout[0]), 8'h0);
        @(negedge clk); rst_n = 1'b1;

        // ---- product-term clock (R7)
        rand_cfg(1'b1);
        bw[0] = '0;
        bw[22] = 36'h1 << 34;       // clock term: input 17 true
        bw[23] = 36'h1 << 21;       // out0 bypass registered, constant 1
        bw[24][21] = 1'b1;          // out1 registered
        bw[27] = 36'h1;
        in_bus = '0;
        program_all();
        repeat (3) @(posedge clk);
        #1;
        check(dout[0] == 1'b0, "R7 global clock ignored", 8'(dout[0]), 8'h0);
        for (int n = 0; n < 20; n++) begin
            logic [17:0] v;
            logic hold;
            @(negedge clk);
            v = 18'($urandom) & 18'h1ffff;
            in_bus = v;
            #2;
            in_bus[17] = 1'b1;
            v[17] = 1'b1;
            #1;
            check(dout[0] == 1'b1, "R7 term clock edge", 8'(dout[0]), 8'h1);
            hold = out_val(1, v);
            check(dout[1] == hold, "R7 term clock data", 8'(dout[1]), 8'(hold));
            @(negedge clk);
            in_bus = 18'($urandom) & 18'h1ffff;
            @(posedge clk); @(posedge clk); #1;
            check(dout[1] == hold, "R7 hold across clk", 8'(dout[1]), 8'(hold));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule